// File: doc/BRIEF.md
# Post-Configuration Reset and DSP Boot Sequencer

This controller takes over once the programmable-logic configuration has finished. It first lets the logic's register reset go. After a fixed wait it lets the controller software reset go. After a longer wait it boots a chain of DSP devices one at a time, each through its own active-low select. The device with the highest index is loaded first, and the others follow in descending order.

Each device is loaded in two stages: a port-setup image, then the main program. For each stage the sequencer asks an external serial sender to transmit the image and waits for that sender to report completion. It then watches a shared acknowledge line for a bounded number of cycles. After the port-setup stage it expects the line low. After the main-program stage it expects the line high. If the expected level does not arrive in time, the whole download starts again from the first device, up to a parameterised number of retries. When the retries are used up, the sequencer raises a sticky error and halts. When every device passes both stages, it raises a sticky ready flag.

All delays are given in microseconds and converted to cycles from a clock-rate parameter given in MHz.

Top module: `dsp_boot_seq`

## Requirements
- R1: `fpga_rst_n_o` is low out of reset. It rises exactly FPGA_RST_US*CLK_MHZ cycles after the clock edge that first samples `cfg_done_i` high.
- R2: `soft_rst_n_o` rises exactly SOFT_RST_US*CLK_MHZ cycles after `fpga_rst_n_o` rises. It is never high while `fpga_rst_n_o` is low. Both resets stay high until `rst_n` is asserted.
- R3: Exactly CS_WAIT_US*CLK_MHZ cycles after `soft_rst_n_o` rises, select `cs_n_o[N_DEV-1]` goes low and all other selects stay high.
- R4: At most one bit of `cs_n_o` is low at a time. Devices are loaded in descending index order. Every hand-over between devices, and every restart, leaves all selects high for at least one cycle.
- R5: For each device, stage 0 (port setup) comes before stage 1 (main program). During each stage `xfer_req_o` is high, `xfer_stage_o` carries the stage number (0 or 1), and the device's select is low. This holds until a cycle that samples `xfer_done_i` high.
- R6: After the stage-0 completion, `ack_i` must be sampled low on one of the next ACK_TIMEOUT_US*CLK_MHZ clock edges. After the stage-1 completion, `ack_i` must be sampled high within the same window. A correct level on the first of those edges passes at once.
- R7: When the acknowledge window expires, all selects go high for one cycle. Loading then restarts at device N_DEV-1, stage 0. At most MAX_RETRY restarts occur.
- R8: A window expiry after MAX_RETRY restarts sets `error_o` and clears `busy_o`. The block then holds all selects high and `xfer_req_o` low until reset, and `error_o` stays high.
- R9: `busy_o` is high from the cycle after `cfg_done_i` is first sampled high until `ready_o` or `error_o` rises. `ready_o` rises after device 0 passes stage 1 and stays high until reset.
- R10: Once the sequence has started, `cfg_done_i` is ignored. Dropping it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done_i | input | 1 | Configuration-complete indication, starts the sequence |
| ack_i | input | 1 | Shared boot acknowledge from the DSP chain |
| xfer_done_i | input | 1 | One-cycle completion pulse from the serial sender |
| fpga_rst_n_o | output | 1 | Logic register reset, active low |
| soft_rst_n_o | output | 1 | Controller software reset, active low |
| cs_n_o | output | N_DEV | Per-device active-low select |
| xfer_req_o | output | 1 | Request to the serial sender to transmit an image |
| xfer_stage_o | output | 1 | Image selector: 0 port setup, 1 main program |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | All devices booted, sticky |
| error_o | output | 1 | Retries exhausted, sticky |

## Verification
The hardest situations to reach are the retry paths: a timeout on the last device's main-program stage, and an acknowledge that arrives one cycle too late. In both, the line is left at a level that the restarted stage 0 either accepts at once or rejects. The bench contains a responding serial-sender and DSP model whose acknowledge delay can be set for each response. Individual responses are made exactly on the last window edge, one edge late, or never. A behavioural reference then predicts every output on every cycle, including the immediate pass after a stage-1 failure and the exhaustion after the final retry.

// File: rtl/dsp_boot_pkg.sv
package dsp_boot_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_CFG,
        ST_FPGA_HOLD,
        ST_SOFT_HOLD,
        ST_CS_HOLD,
        ST_SEND,
        ST_ACK,
        ST_SWITCH,
        ST_RETRY,
        ST_READY,
        ST_ERROR
    } boot_state_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign hit_o = (cnt_q == limit_i - W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (!hit_o) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !clr_i && $stable(limit_i)) |=> hit_o); // R1
endmodule

// File: rtl/boot_ack_check.sv
module boot_ack_check (
    input  logic armed_i,
    input  logic stage_i,
    input  logic ack_i,
    input  logic hit_i,
    output logic pass_o,
    output logic timeout_o
);
    // stage 0 expects the line low, stage 1 expects it high
    always_comb begin
        pass_o    = armed_i && (ack_i == stage_i);
        timeout_o = armed_i && !pass_o && hit_i;
    end
endmodule

// File: rtl/boot_select.sv
module boot_select #(
    parameter int unsigned N_DEV = 2,
    parameter int unsigned DW    = 1
) (
    input  logic          en_i,
    input  logic [DW-1:0] dev_i,
    output logic [N_DEV-1:0] cs_n_o
);
    for (genvar i = 0; i < N_DEV; i++) begin : g_cs
        assign cs_n_o[i] = !(en_i && (dev_i == DW'(i)));
    end
endmodule

// File: rtl/dsp_boot_seq.sv
module dsp_boot_seq
    import dsp_boot_pkg::*;
#(
    parameter int unsigned N_DEV          = 2,
    parameter int unsigned CLK_MHZ        = 125,
    parameter int unsigned FPGA_RST_US    = 1000,
    parameter int unsigned SOFT_RST_US    = 5000,
    parameter int unsigned CS_WAIT_US     = 500000,
    parameter int unsigned ACK_TIMEOUT_US = 6000,
    parameter int unsigned MAX_RETRY      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done_i,
    input  logic             ack_i,
    input  logic             xfer_done_i,
    output logic             fpga_rst_n_o,
    output logic             soft_rst_n_o,
    output logic [N_DEV-1:0] cs_n_o,
    output logic             xfer_req_o,
    output logic             xfer_stage_o,
    output logic             busy_o,
    output logic             ready_o,
    output logic             error_o
);
    localparam int unsigned FPGA_CYC = CLK_MHZ * FPGA_RST_US;
    localparam int unsigned SOFT_CYC = CLK_MHZ * SOFT_RST_US;
    localparam int unsigned CS_CYC   = CLK_MHZ * CS_WAIT_US;
    localparam int unsigned ACK_CYC  = CLK_MHZ * ACK_TIMEOUT_US;
    localparam int unsigned MAX_CYC  = max4(FPGA_CYC, SOFT_CYC, CS_CYC, ACK_CYC);
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);
    localparam int unsigned DW       = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int unsigned RW       = $clog2(MAX_RETRY + 2);

    typedef struct packed {
        boot_state_e   st;
        logic [DW-1:0] dev;
        logic          stage;
        logic [RW-1:0] tries;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [CW-1:0] limit;
    logic          hit, ack_pass, ack_timeout, tmr_clr, sel_en;

    always_comb begin
        case (ctl_q.st)
            ST_FPGA_HOLD: limit = CW'(FPGA_CYC);
            ST_SOFT_HOLD: limit = CW'(SOFT_CYC);
            ST_CS_HOLD:   limit = CW'(CS_CYC);
            default:      limit = CW'(ACK_CYC);
        endcase
    end

    assign tmr_clr = (ctl_d.st != ctl_q.st);
    assign sel_en  = (ctl_q.st == ST_SEND) || (ctl_q.st == ST_ACK);

    boot_timer #(.W(CW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .limit_i (limit),
        .hit_o   (hit)
    );

    boot_ack_check i_ack_check (
        .armed_i   (ctl_q.st == ST_ACK),
        .stage_i   (ctl_q.stage),
        .ack_i     (ack_i),
        .hit_i     (hit),
        .pass_o    (ack_pass),
        .timeout_o (ack_timeout)
    );

    boot_select #(.N_DEV(N_DEV), .DW(DW)) i_select (
        .en_i   (sel_en),
        .dev_i  (ctl_q.dev),
        .cs_n_o (cs_n_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_WAIT_CFG:  if (cfg_done_i) ctl_d.st = ST_FPGA_HOLD;
            ST_FPGA_HOLD: if (hit) ctl_d.st = ST_SOFT_HOLD;
            ST_SOFT_HOLD: if (hit) ctl_d.st = ST_CS_HOLD;
            ST_CS_HOLD: begin
                if (hit) begin
                    ctl_d.st    = ST_SEND;
                    ctl_d.dev   = DW'(N_DEV - 1);
                    ctl_d.stage = 1'b0;
                end
            end
            ST_SEND: if (xfer_done_i) ctl_d.st = ST_ACK;
            ST_ACK: begin
                if (ack_pass) begin
                    if (!ctl_q.stage) begin
                        ctl_d.st    = ST_SEND;
                        ctl_d.stage = 1'b1;
                    end else if (ctl_q.dev == '0) begin
                        ctl_d.st = ST_READY;
                    end else begin
                        ctl_d.st = ST_SWITCH;
                    end
                end else if (ack_timeout) begin
                    if (ctl_q.tries == RW'(MAX_RETRY)) begin
                        ctl_d.st = ST_ERROR;
                    end else begin
                        ctl_d.st    = ST_RETRY;
                        ctl_d.tries = ctl_q.tries + RW'(1);
                    end
                end
            end
            ST_SWITCH: begin
                ctl_d.st    = ST_SEND;
                ctl_d.dev   = ctl_q.dev - DW'(1);
                ctl_d.stage = 1'b0;
            end
            ST_RETRY: begin
                ctl_d.st    = ST_SEND;
                ctl_d.dev   = DW'(N_DEV - 1);
                ctl_d.stage = 1'b0;
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_WAIT_CFG, dev: '0, stage: 1'b0, tries: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fpga_rst_n_o = (ctl_q.st > ST_FPGA_HOLD);
    assign soft_rst_n_o = (ctl_q.st > ST_SOFT_HOLD);
    assign xfer_req_o   = (ctl_q.st == ST_SEND);
    assign xfer_stage_o = ctl_q.stage;
    assign busy_o       = (ctl_q.st != ST_WAIT_CFG) && (ctl_q.st != ST_READY)
                          && (ctl_q.st != ST_ERROR);
    assign ready_o      = (ctl_q.st == ST_READY);
    assign error_o      = (ctl_q.st == ST_ERROR);

    AST_RST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_n_o |-> fpga_rst_n_o); // R2
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fpga_rst_n_o |=> (fpga_rst_n_o && ($past(soft_rst_n_o) -> soft_rst_n_o))); // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R4
    AST_SELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n_o) && !(&$past(cs_n_o))) |-> $stable(cs_n_o)); // R4
    AST_REQ_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (!(&cs_n_o) && soft_rst_n_o)); // R5
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && $past(xfer_req_o)) |-> $stable(xfer_stage_o)); // R5
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.tries <= RW'(MAX_RETRY)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> (error_o && (&cs_n_o) && !xfer_req_o)); // R8
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R9
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!ready_o && !error_o)); // R9
endmodule

// File: tb/test_dsp_boot_seq.sv
module test_dsp_boot_seq;
    localparam int N_DEV = 2;
    localparam int TF    = 10;
    localparam int TS    = 20;
    localparam int TC    = 30;
    localparam int TA    = 15;
    localparam int MR    = 3;
    localparam int LAT   = 2;

    logic clk = 1'b0, rst_n = 1'b0, cfg_done = 1'b0, xfer_done = 1'b0, ack = 1'b1;
    logic fpga_rst_n, soft_rst_n, xfer_req, xfer_stage, busy, ready, error_f;
    logic [N_DEV-1:0] cs_n;

    always #4 clk = ~clk;

    dsp_boot_seq #(
        .N_DEV(N_DEV), .CLK_MHZ(1), .FPGA_RST_US(TF), .SOFT_RST_US(TS),
        .CS_WAIT_US(TC), .ACK_TIMEOUT_US(TA), .MAX_RETRY(MR)
    ) i_dsp_boot_seq (
        .clk(clk), .rst_n(rst_n), .cfg_done_i(cfg_done), .ack_i(ack),
        .xfer_done_i(xfer_done), .fpga_rst_n_o(fpga_rst_n), .soft_rst_n_o(soft_rst_n),
        .cs_n_o(cs_n), .xfer_req_o(xfer_req), .xfer_stage_o(xfer_stage),
        .busy_o(busy), .ready_o(ready), .error_o(error_f)
    );

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------- behavioural reference: phase names as integers ----------
    // 0 idle,1 logic-reset wait,2 soft-reset wait,3 select wait,4 sending,
    // 5 acknowledge window,6 device hand-over,7 restart gap,8 ready,9 error
    int m_phase, m_t, m_dev, m_stg, m_tries;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_t = 0; m_dev = 0; m_stg = 0; m_tries = 0;
        end else begin
            case (m_phase)
                0: if (cfg_done) begin m_phase = 1; m_t = 0; end
                1: if (m_t == TF - 1) begin m_phase = 2; m_t = 0; end else m_t++;
                2: if (m_t == TS - 1) begin m_phase = 3; m_t = 0; end else m_t++;
                3: if (m_t == TC - 1) begin m_phase = 4; m_dev = N_DEV - 1; m_stg = 0; end
                   else m_t++;
                4: if (xfer_done) begin m_phase = 5; m_t = 0; end
                5: begin
                    if (int'(ack) == m_stg) begin
                        if (m_stg == 0) begin m_stg = 1; m_phase = 4; end
                        else if (m_dev == 0) m_phase = 8;
                        else m_phase = 6;
                    end else if (m_t == TA - 1) begin
                        if (m_tries == MR) m_phase = 9;
                        else begin m_tries++; m_phase = 7; end
                    end else m_t++;
                end
                6: begin m_dev--; m_stg = 0; m_phase = 4; end
                7: begin m_dev = N_DEV - 1; m_stg = 0; m_phase = 4; end
                default: ;
            endcase
        end
    end

    // ---------- peer: serial sender and DSP acknowledge ----------
    int good_delay = 3, bad_from = -1, bad_to = -1, bad_delay = -1;
    int resp = 0, ack_cnt = -1, x_left = 0, dly = 0, top_falls = 0;
    bit in_x = 0, ack_val = 0, x_stage = 0, prev_top = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            // every-cycle comparison with the reference
            chk("R1 fpga_rst_n", int'(fpga_rst_n), int'(m_phase >= 2));
            chk("R2 soft_rst_n", int'(soft_rst_n), int'(m_phase >= 3));
            for (int i = 0; i < N_DEV; i++)
                chk("R4 cs_n", int'(cs_n[i]), int'(!((m_phase == 4 || m_phase == 5) && m_dev == i)));
            chk("R5 xfer_req", int'(xfer_req), int'(m_phase == 4));
            if (m_phase == 4) chk("R5 xfer_stage", int'(xfer_stage), m_stg);
            chk("R9 busy", int'(busy), int'(m_phase >= 1 && m_phase <= 7));
            chk("R9 ready", int'(ready), int'(m_phase == 8));
            chk("R8 error", int'(error_f), int'(m_phase == 9));
        end
        if (prev_top && !cs_n[N_DEV-1]) top_falls++;
        prev_top = cs_n[N_DEV-1];
        if (!rst_n) begin
            in_x = 0; xfer_done = 0; ack_cnt = -1; resp = 0; ack = 1;
        end else begin
            if (ack_cnt > 0) begin
                ack_cnt--;
                if (ack_cnt == 0) begin ack = ack_val; ack_cnt = -1; end
            end
            if (xfer_done) begin
                xfer_done = 0;
                dly = (resp >= bad_from && resp <= bad_to) ? bad_delay : good_delay;
                resp++;
                ack_val = x_stage;
                if (dly == 0) ack = ack_val;
                else if (dly > 0) ack_cnt = dly;
            end else if (in_x) begin
                x_left--;
                if (x_left == 0) begin xfer_done = 1; in_x = 0; end
            end else if (xfer_req) begin
                in_x = 1; x_left = LAT; x_stage = xfer_stage;
            end
        end
    end

    task automatic do_reset(input int gd, input int bf, input int bt, input int bd);
        @(negedge clk);
        rst_n = 0; cfg_done = 0;
        good_delay = gd; bad_from = bf; bad_to = bt; bad_delay = bd;
        repeat (3) @(negedge clk);
        rst_n = 1; top_falls = 0;
    endtask

    task automatic run_to_end();
        while (!ready && !error_f) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // case A: clean boot with reset-release timing
        do_reset(3, -1, -1, -1);
        @(negedge clk);
        chk("R1 reset fpga low", int'(fpga_rst_n), 0);
        chk("R9 reset idle busy", int'(busy), 0);
        chk("R4 reset selects high", int'(cs_n), 3);
        cfg_done = 1;
        n = 0; do begin @(negedge clk); n++; end while (!fpga_rst_n);
        chk("R1 logic reset delay", n, TF + 1);
        cfg_done = 0; // R10: dropped after start, must be ignored
        n = 0; do begin @(negedge clk); n++; end while (!soft_rst_n);
        chk("R2 soft reset delay", n, TS);
        n = 0; do begin @(negedge clk); n++; end while (&cs_n);
        chk("R3 select delay", n, TC);
        chk("R3 highest device first", int'(cs_n), 1);
        chk("R5 first stage is port setup", int'(xfer_stage), 0);
        run_to_end();
        chk("R10 ready despite cfg drop", int'(ready), 1);
        chk("R9 single pass", top_falls, 1);
        repeat (20) @(negedge clk);
        chk("R9 ready sticky", int'(ready), 1);

        // case B: acknowledge on the last edge of each window
        do_reset(TA - 1, -1, -1, -1);
        cfg_done = 1;
        run_to_end();
        chk("R6 last-edge ack passes", int'(ready), 1);
        chk("R6 no restart", top_falls, 1);

        // case C: first acknowledge one edge late
        do_reset(3, 0, 0, TA);
        cfg_done = 1;
        run_to_end();
        chk("R7 late ack retried then ready", int'(ready), 1);
        chk("R7 one restart", top_falls, 2);

        // case D: acknowledge never arrives
        do_reset(3, 0, 1000, -1);
        cfg_done = 1;
        run_to_end();
        chk("R8 error after retries", int'(error_f), 1);
        chk("R8 attempts", top_falls, MR + 1);
        repeat (40) @(negedge clk);
        chk("R8 error sticky", int'(error_f), 1);
        chk("R8 halted selects", int'(cs_n), 3);
        chk("R8 no request", int'(xfer_req), 0);
        chk("R8 not busy", int'(busy), 0);

        // case E: main-program stage of last device fails once
        do_reset(3, 3, 3, -1);
        cfg_done = 1;
        run_to_end();
        chk("R6 stage-1 failure recovers", int'(ready), 1);
        chk("R7 restart from top device", top_falls, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule